// File: doc/BRIEF.md
# Two-Channel Coded-Prescaler PWM Generator

This block generates two independent pulse-width-modulated outputs from a single module clock. Each channel first slows the clock through a prescaler. A 4-bit code in the channel's control field selects the prescaler ratio from a fixed, non-binary set. The prescaled ticks then drive a 16-bit counter that sets the period and the number of active ticks. One word-wide control register holds the settings for both channels. Each channel also has a period/duty register. All registers are reached over a plain 32-bit write-strobe and read bus.

Software writes a period/duty value into a shadow copy. The channel moves that copy into its active counter only at a period boundary, or at once while the channel is idle, so a running waveform never shows a torn period. A per-channel ready flag in the control register shows whether a shadow value is still waiting. Each channel has three further controls. A polarity bit selects which level counts as active. A gating bit stops the counter and clears the prescaler at once. A bypass bit routes the undivided module clock straight to the pin and overrides every other setting.

The bus is a register interface with no data stream. It therefore uses plain strobes with no back-pressure. A write takes effect on the clock edge where `reg_we` is high. Reads are combinational from `reg_addr`.

Top module: `pwm_dual_ctrl`

## Requirements
- R1: The control register is at byte address 0x0. The period/duty register of channel n is at 0x4 + 4*n. Channel n's control field starts at bit 15*n and is laid out as follows: bits [3:0] hold the prescaler code, bit 4 is enable, bit 5 is the active level, bit 6 is gating, bit 7 is mode, bit 8 is pulse and bit 9 is bypass. These bits read back as written. All other control bits read 0, except the ready flags. A write to any other address changes nothing, and reading such an address returns 0.
- R2: Prescaler codes 0 to 4 divide by 120, 180, 240, 360 and 480. Codes 8 to 12 divide by 12000, 24000, 36000, 48000 and 72000. Code 15 divides by 1. Codes 5 to 7, 13 and 14 hold the counter where it is.
- R3: In a period/duty register, bits [31:16] hold the period minus one and bits [15:0] hold the duty. A running channel cycles through period+1 prescaled ticks. It is active during the first duty ticks of each period.
- R4: A channel starts a waveform only when its enable bit and its gating bit are both 1. Otherwise it stays at the inactive level.
- R5: When the active-level bit is 1, the pin is high while the channel is active and low otherwise. When the bit is 0, the pin is inverted, so an idle channel drives 1.
- R6: While bypass is 1, the pin equals the module clock and every other field is ignored. The period in progress is abandoned, and the counter restarts from tick 0 once bypass clears.
- R7: A write to a period/duty register goes to its shadow copy. The shadow loads at the end of the current period, or on the next clock edge if the channel is idle. Ready flag n, at control bit 28+n and read-only, reads 0 from the write until the load.
- R8: When enable is cleared on a running channel, the channel completes its current period and then holds the inactive level.
- R9: When gating is cleared, the counter and the prescaler return to zero on the next edge, and the pin goes to the inactive level.
- R10: A duty greater than the stored period field gives a constant active level. A duty of 0 gives a constant inactive level.
- R11: The mode and pulse bits are stored and read back but have no effect on the waveform.
- R12: The two channels run independently, each with its own prescaler code, period, duty and polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock; also the bypass source |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe, sampled on the rising edge |
| reg_addr | input | 4 | Byte address for reads and writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
Three situations are hard to reach from the ports, and each needs a write timed against a period that is already running. The first is a shadow write landing mid-period. The second is an enable drop partway through a period. The third is a prescaler code changed to an invalid value while the counter is running. The stimulus uses divide-by-1 periods of a few ticks so that these writes fall at known tick positions. It reads the ready flag on the cycle just after a shadow write. It also runs one long channel at divide-by-120 while the other is repeatedly reconfigured, to show that the channels do not interfere. A behavioural model follows every tick, and the pin is compared on both clock phases so that bypass is checked against the clock level.

// File: rtl/pwm_dual_pkg.sv
package pwm_dual_pkg;
  localparam int PRE_W   = 17;
  localparam int FIELD_W = 10;
  localparam int CODE_W  = 4;

  typedef struct packed {
    logic              byp;
    logic              pulse;
    logic              mode;
    logic              gate;
    logic              level;
    logic              en;
    logic [CODE_W-1:0] code;
  } ch_cfg_t;

  // Ratio for a prescaler code; 0 marks a code that stalls the counter.
  function automatic logic [PRE_W-1:0] div_of(input logic [CODE_W-1:0] c);
    logic [PRE_W-1:0] d;
    case (c)
      4'd0:  d = PRE_W'(120);
      4'd1:  d = PRE_W'(180);
      4'd2:  d = PRE_W'(240);
      4'd3:  d = PRE_W'(360);
      4'd4:  d = PRE_W'(480);
      4'd8:  d = PRE_W'(12000);
      4'd9:  d = PRE_W'(24000);
      4'd10: d = PRE_W'(36000);
      4'd11: d = PRE_W'(48000);
      4'd12: d = PRE_W'(72000);
      4'd15: d = PRE_W'(1);
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
  import pwm_dual_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_i,
  input  logic              run_i,
  output logic              valid_o,
  output logic              tick_o
);
  logic [PRE_W-1:0] div;
  logic [PRE_W-1:0] cnt_q;
  logic             last;

  assign div     = div_of(code_i);
  assign valid_o = (div != '0);
  // >= so a ratio lowered mid-count still wraps promptly
  assign last    = valid_o && (cnt_q >= div - PRE_W'(1));
  assign tick_o  = run_i && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!run_i || !valid_o) cnt_q <= '0;
    else if (last)              cnt_q <= '0;
    else                        cnt_q <= cnt_q + PRE_W'(1);
  end

  // R9: a stopped prescaler restarts from zero
  p_pre_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_dual_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               en_i,
  input  logic               level_i,
  input  logic               gate_i,
  input  logic               byp_i,
  input  logic               shad_we_i,
  input  logic [2*CNT_W-1:0] shad_wdata_i,
  output logic [2*CNT_W-1:0] shad_o,
  output logic               ready_o,
  output logic               wave_o
);
  localparam int WORD_W = 2 * CNT_W;

  logic              halt, valid, tick, boundary, load, act;
  logic              run_q, pend_q;
  logic [CNT_W-1:0]  cnt_q, prd_q, dty_q;
  logic [WORD_W-1:0] shad_q;

  assign halt = !gate_i || byp_i;

  pwm_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .code_i (code_i),
    .run_i  (!halt),
    .valid_o(valid),
    .tick_o (tick)
  );

  assign boundary = run_q && tick && (cnt_q == prd_q);
  assign load     = pend_q && (!run_q || boundary);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (halt) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (!run_q) begin
      if (en_i && valid) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end
    end else if (tick) begin
      if (cnt_q == prd_q) begin
        cnt_q <= '0;
        if (!en_i) run_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shad_q <= '0;
      pend_q <= 1'b0;
      prd_q  <= '0;
      dty_q  <= '0;
    end else begin
      if (load) begin
        prd_q <= shad_q[WORD_W-1:CNT_W];
        dty_q <= shad_q[CNT_W-1:0];
      end
      if (shad_we_i) begin
        shad_q <= shad_wdata_i;
        pend_q <= 1'b1;
      end else if (load) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign act     = run_q && (cnt_q < dty_q);
  assign wave_o  = level_i ? act : !act;
  assign ready_o = !pend_q;
  assign shad_o  = shad_q;

  // R7: a fresh shadow write is always pending on the next cycle
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    shad_we_i |=> !ready_o);
  // R9: gating off or bypass empties the counter
  p_halt_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!run_q && cnt_q == '0));
  // R3: tick index never passes the loaded period
  p_cnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q <= prd_q));
  // R8: with enable low, running continues until the period ends
  p_finish_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !halt && !en_i && !boundary) |=> run_q);
  // R2: an invalid code freezes the counter
  p_stall_invalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid && !halt) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_dual_ctrl.sv
module pwm_dual_ctrl
  import pwm_dual_pkg::*;
#(
  parameter int NUM_CH    = 2,
  parameter int CNT_W     = 16,
  parameter int CH_STRIDE = 15,
  parameter int RDY_BASE  = 28,
  parameter int ADDR_W    = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [2*CNT_W-1:0]  reg_wdata,
  output logic [2*CNT_W-1:0]  reg_rdata,
  output logic [NUM_CH-1:0]   pwm_out
);
  localparam int DATA_W = 2 * CNT_W;

  function automatic logic [DATA_W-1:0] field_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < NUM_CH; n++) m[n*CH_STRIDE +: FIELD_W] = '1;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_MASK = field_mask();

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] shad_rd [NUM_CH];
  logic [NUM_CH-1:0] ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ctrl_q <= '0;
    else if (reg_we && reg_addr == '0)   ctrl_q <= reg_wdata & CTRL_MASK;
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    ch_cfg_t cfg;
    logic    wave;
    assign cfg = ch_cfg_t'(ctrl_q[n*CH_STRIDE +: FIELD_W]);

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk         (clk),
      .rst_n       (rst_n),
      .code_i      (cfg.code),
      .en_i        (cfg.en),
      .level_i     (cfg.level),
      .gate_i      (cfg.gate),
      .byp_i       (cfg.byp),
      .shad_we_i   (reg_we && reg_addr == ADDR_W'(4 + 4*n)),
      .shad_wdata_i(reg_wdata),
      .shad_o      (shad_rd[n]),
      .ready_o     (ready[n]),
      .wave_o      (wave)
    );

    assign pwm_out[n] = cfg.byp ? clk : wave;
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == '0) begin
      reg_rdata = ctrl_q;
      for (int n = 0; n < NUM_CH; n++) reg_rdata[RDY_BASE+n] = ready[n];
    end
    for (int n = 0; n < NUM_CH; n++)
      if (reg_addr == ADDR_W'(4 + 4*n)) reg_rdata = shad_rd[n];
  end

  // R1: a control write keeps exactly the mapped field bits
  p_ctrl_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0) |=> (ctrl_q == ($past(reg_wdata) & CTRL_MASK)));
endmodule

// File: tb/test_pwm_dual_ctrl.sv
module test_pwm_dual_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  pwm_out;

  pwm_dual_ctrl i_pwm_dual_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 0;

  // Behavioural reference state
  bit [31:0] m_ctrl;
  bit [31:0] m_shad [2];
  bit        m_pend [2];
  bit        m_run  [2];
  int        m_pre  [2];
  int        m_cnt  [2];
  int        m_prd  [2];
  int        m_dty  [2];

  function automatic int ratio(int c);
    case (c)
      0: return 120;    1: return 180;    2: return 240;
      3: return 360;    4: return 480;    8: return 12000;
      9: return 24000; 10: return 36000; 11: return 48000;
      12: return 72000; 15: return 1;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0;
      for (int c = 0; c < 2; c++) begin
        m_shad[c] = 0; m_pend[c] = 0; m_run[c] = 0;
        m_pre[c] = 0;  m_cnt[c] = 0;  m_prd[c] = 0; m_dty[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        bit [9:0] f;
        int d, pre_n, cnt_n;
        bit stop, tk, bnd, ld, run_n;
        f = 10'(m_ctrl >> (15*c));
        d = ratio(int'(f[3:0]));
        stop = !f[6] || f[9];
        tk  = !stop && d != 0 && m_pre[c] >= d - 1;
        bnd = m_run[c] && tk && m_cnt[c] == m_prd[c];
        ld  = m_pend[c] && (!m_run[c] || bnd);
        pre_n = (stop || d == 0 || tk) ? 0 : m_pre[c] + 1;
        run_n = m_run[c]; cnt_n = m_cnt[c];
        if (stop) begin run_n = 0; cnt_n = 0; end
        else if (!m_run[c]) begin
          if (f[4] && d != 0) begin run_n = 1; cnt_n = 0; end
        end else if (tk) begin
          if (bnd) begin cnt_n = 0; if (!f[4]) run_n = 0; end
          else cnt_n = m_cnt[c] + 1;
        end
        if (ld) begin
          m_prd[c] = int'(m_shad[c][31:16]);
          m_dty[c] = int'(m_shad[c][15:0]);
          m_pend[c] = 0;
        end
        m_pre[c] = pre_n; m_run[c] = run_n; m_cnt[c] = cnt_n;
      end
      if (reg_we) begin
        if (reg_addr == 0) m_ctrl = reg_wdata & 32'h01FF_83FF;
        for (int c = 0; c < 2; c++)
          if (reg_addr == 4'(4 + 4*c)) begin m_shad[c] = reg_wdata; m_pend[c] = 1; end
      end
    end
  end

  function automatic bit exp_pin(int c, bit clkv);
    bit [9:0] f;
    bit act;
    f = 10'(m_ctrl >> (15*c));
    if (f[9]) return clkv;
    act = m_run[c] && m_cnt[c] < m_dty[c];
    return f[5] ? act : !act;
  endfunction

  function automatic bit [31:0] exp_rd();
    bit [31:0] r;
    r = 0;
    if (reg_addr == 0) begin
      r = m_ctrl;
      r[28] = !m_pend[0];
      r[29] = !m_pend[1];
    end
    if (reg_addr == 4) r = m_shad[0];
    if (reg_addr == 8) r = m_shad[1];
    return r;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all(bit clkv);
    for (int c = 0; c < 2; c++)
      chk(pwm_out[c] == exp_pin(c, clkv), cur_req, pwm_out[c], exp_pin(c, clkv));
    chk(reg_rdata == exp_rd(), cur_req, reg_rdata, exp_rd());
  endtask

  always @(posedge clk) begin #2; if (rst_n && !done) compare_all(1'b1); end
  always @(negedge clk) begin #2; if (rst_n && !done) compare_all(1'b0); end

  task automatic wr(bit [3:0] a, bit [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hold_level(int c, bit v, int n, string req);
    repeat (n) begin
      @(negedge clk); #1;
      chk(pwm_out[c] == v, req, pwm_out[c], v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    #1;
    // Reset state: idle inverted pins drive 1, ready flags set
    chk(pwm_out == 2'b11, "R5 reset", pwm_out, 2'b11);
    chk(reg_rdata == 32'h3000_0000, "R1 reset", reg_rdata, 32'h3000_0000);

    cur_req = "R3";
    wr(4, 32'h0004_0002);
    wr(0, 32'h0000_007F);
    idle(30);

    cur_req = "R7";
    wr(4, 32'h0004_0004);
    reg_addr = 0; #1;
    chk(reg_rdata[28] == 1'b0, "R7 ready low", reg_rdata[28], 0);
    idle(20);
    chk(reg_rdata[28] == 1'b1, "R7 ready back", reg_rdata[28], 1);

    cur_req = "R5";
    wr(0, 32'h0000_005F);
    idle(20);

    cur_req = "R12";
    wr(8, 32'h0001_0001);
    wr(0, 32'h0038_005F);
    idle(600);

    cur_req = "R2";
    wr(0, 32'h0038_0075);
    idle(30);

    cur_req = "R10";
    wr(4, 32'h0003_0004);
    wr(0, 32'h0038_007F);
    idle(10);
    hold_level(0, 1'b1, 8, "R10 full duty");
    wr(4, 32'h0003_0000);
    idle(10);
    hold_level(0, 1'b0, 8, "R10 zero duty");

    cur_req = "R8";
    wr(4, 32'h0009_0005);
    idle(15);
    wr(0, 32'h0038_006F);
    idle(30);
    hold_level(0, 1'b0, 4, "R8 idle after finish");

    cur_req = "R4";
    wr(0, 32'h0038_003F);
    idle(10);

    cur_req = "R9";
    wr(0, 32'h0038_007F);
    idle(7);
    wr(0, 32'h0038_003F);
    hold_level(0, 1'b0, 6, "R9 gated off");

    cur_req = "R6";
    wr(0, 32'h0038_027F);
    @(posedge clk); #2;
    chk(pwm_out[0] == 1'b1, "R6 bypass high", pwm_out[0], 1);
    @(negedge clk); #2;
    chk(pwm_out[0] == 1'b0, "R6 bypass low", pwm_out[0], 0);
    idle(10);
    wr(0, 32'h0038_007F);
    idle(10);

    cur_req = "R11";
    wr(0, 32'h0038_01FF);
    reg_addr = 0; #1;
    chk((reg_rdata & 32'h01FF_83FF) == 32'h0038_01FF, "R11 readback",
        reg_rdata, 32'h0038_01FF);
    idle(20);

    cur_req = "R1";
    wr(12, 32'hFFFF_FFFF);
    reg_addr = 12; #1;
    chk(reg_rdata == 0, "R1 unmapped", reg_rdata, 0);
    reg_addr = 4; #1;
    chk(reg_rdata == 32'h0009_0005, "R1 ch0 reg", reg_rdata, 32'h0009_0005);
    idle(5);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule